// File: doc/BRIEF.md
# Vector FMA Destination Writeback Merger

This block builds the 256-bit value written back to the destination register of a vector fused-multiply-add unit. The destination register is also the first source operand. The block therefore merges three things: the computed lane results from the arithmetic core, the original destination content, and zero. It does no arithmetic. It decides, for each 32-bit granule, which of the three sources fills that granule. The decision depends on the element precision, on whether the operation is packed or scalar, and on the vector length.

A packed 256-bit operation replaces every lane: eight single lanes or four double lanes. A packed 128-bit operation replaces the lower half and clears the upper half. A scalar operation writes only the lowest element, 32 or 64 bits wide. It keeps the original destination content in the rest of the lower 128 bits and clears bits 255:128. This is neither a plain write-mask nor a full overwrite. The merged word is registered and is presented one cycle after the input, with a one-cycle valid pulse.

Top module: `fma_wb_merge`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is all zeros.
- R2: out_valid_o is 1 in the cycle after each cycle in which in_valid_i is 1, and 0 in the cycle after each cycle in which in_valid_i is 0.
- R3: Packed 256-bit mode (scalar_i=0, len256_i=1) makes out_data_o equal to res_i for the accepted input.
- R4: Packed 128-bit mode (scalar_i=0, len256_i=0) makes out_data_o[127:0] equal to res_i[127:0] and out_data_o[255:128] zero.
- R5: Scalar single mode (scalar_i=1, dbl_i=0) makes out_data_o[31:0] equal to res_i[31:0], out_data_o[127:32] equal to dst_i[127:32] and out_data_o[255:128] zero, whatever len256_i is.
- R6: Scalar double mode (scalar_i=1, dbl_i=1) makes out_data_o[63:0] equal to res_i[63:0], out_data_o[127:64] equal to dst_i[127:64] and out_data_o[255:128] zero, whatever len256_i is.
- R7: In packed mode dbl_i has no effect: the merged word is the same for dbl_i=0 and dbl_i=1.
- R8: In a cycle in which in_valid_i is 0, out_data_o keeps its previous value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input operands and mode are valid this cycle |
| dst_i | input | 256 | Original content of the first source/destination register |
| res_i | input | 256 | Per-lane results from the arithmetic core |
| dbl_i | input | 1 | 1 selects double precision (64-bit elements), 0 selects single precision (32-bit elements) |
| scalar_i | input | 1 | 1 selects scalar operation, 0 selects packed operation |
| len256_i | input | 1 | 1 selects a 256-bit vector, 0 selects a 128-bit vector |
| out_valid_o | output | 1 | Merged word valid, one cycle per accepted input |
| out_data_o | output | 256 | Merged destination word |

## Verification
All eight combinations of precision, packed/scalar and length are applied. Each uses random destination and result words, complementary all-ones/all-zeros words, and alternating bit patterns. Because the destination and result words differ in every granule, each pattern shows at each granule boundary whether that granule came from the result, the destination or zero. This separates the 32-bit scalar boundary from the 64-bit one and the 128-bit packed length from the 256-bit one. Packed inputs are repeated with both precision values to show that precision has no effect there. Valid pulses are separated by idle cycles and also sent back to back, which shows both the one-cycle valid timing and the holding of the word between inputs.

// File: rtl/fma_wb_pkg.sv
package fma_wb_pkg;
  // Source of one 32-bit granule of the merged word
  typedef enum logic [1:0] {
    SRC_RES  = 2'd0,
    SRC_DST  = 2'd1,
    SRC_ZERO = 2'd2
  } src_e;
endpackage

// File: rtl/fma_wb_sel_gen.sv
module fma_wb_sel_gen
  import fma_wb_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int GRAN_W = 32,
  parameter int DP_W   = 64,
  localparam int NGRAN = VEC_W / GRAN_W
) (
  input  logic               dbl_i,
  input  logic               scalar_i,
  input  logic               len256_i,
  output src_e [NGRAN-1:0]   sel_o
);
  localparam int HALF_G = NGRAN / 2;
  localparam int DP_G   = DP_W / GRAN_W;

  int unsigned elem_g;
  int unsigned pk_g;

  always_comb begin
    elem_g = dbl_i ? DP_G : 1;
    pk_g   = len256_i ? NGRAN : HALF_G;
  end

  for (genvar g = 0; g < NGRAN; g++) begin : g_sel
    always_comb begin
      if (scalar_i) begin
        if (g < elem_g)      sel_o[g] = SRC_RES;
        else if (g < HALF_G) sel_o[g] = SRC_DST;
        else                 sel_o[g] = SRC_ZERO;
      end else begin
        sel_o[g] = (g < pk_g) ? SRC_RES : SRC_ZERO;
      end
    end
  end
endmodule

// File: rtl/fma_wb_gran_mux.sv
module fma_wb_gran_mux
  import fma_wb_pkg::*;
#(
  parameter int GRAN_W = 32
) (
  input  src_e              sel_i,
  input  logic [GRAN_W-1:0] res_i,
  input  logic [GRAN_W-1:0] dst_i,
  output logic [GRAN_W-1:0] out_o
);
  always_comb begin
    unique case (sel_i)
      SRC_RES: out_o = res_i;
      SRC_DST: out_o = dst_i;
      default: out_o = '0;
    endcase
  end
endmodule

// File: rtl/fma_wb_merge.sv
module fma_wb_merge
  import fma_wb_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int GRAN_W = 32,
  parameter int DP_W   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] res_i,
  input  logic             dbl_i,
  input  logic             scalar_i,
  input  logic             len256_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] out_data_o
);
  localparam int NGRAN = VEC_W / GRAN_W;

  src_e [NGRAN-1:0] sel;
  logic [VEC_W-1:0] merged;

  fma_wb_sel_gen #(
    .VEC_W (VEC_W),
    .GRAN_W(GRAN_W),
    .DP_W  (DP_W)
  ) u_sel (
    .dbl_i   (dbl_i),
    .scalar_i(scalar_i),
    .len256_i(len256_i),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NGRAN; g++) begin : g_gran
    fma_wb_gran_mux #(.GRAN_W(GRAN_W)) u_mux (
      .sel_i(sel[g]),
      .res_i(res_i[g*GRAN_W +: GRAN_W]),
      .dst_i(dst_i[g*GRAN_W +: GRAN_W]),
      .out_o(merged[g*GRAN_W +: GRAN_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= merged;
    end
  end
endmodule

// File: rtl/fma_wb_merge_chk.sv
module fma_wb_merge_chk #(
  parameter int VEC_W  = 256,
  parameter int GRAN_W = 32,
  parameter int DP_W   = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [VEC_W-1:0] dst_i,
  input logic [VEC_W-1:0] res_i,
  input logic             dbl_i,
  input logic             scalar_i,
  input logic             len256_i,
  input logic             out_valid_o,
  input logic [VEC_W-1:0] out_data_o
);
  localparam int HALF = VEC_W / 2;

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_full_res_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !scalar_i && len256_i) |=> (out_data_o == $past(res_i)));
  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !scalar_i && !len256_i) |=> (out_data_o[VEC_W-1:HALF] == '0));
  p_sp_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && scalar_i && !dbl_i) |=>
      (out_data_o[HALF-1:GRAN_W] == $past(dst_i[HALF-1:GRAN_W]) &&
       out_data_o[VEC_W-1:HALF] == '0));
  p_dp_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && scalar_i && dbl_i) |=>
      (out_data_o[DP_W-1:0] == $past(res_i[DP_W-1:0]) &&
       out_data_o[HALF-1:DP_W] == $past(dst_i[HALF-1:DP_W])));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));
endmodule

bind fma_wb_merge fma_wb_merge_chk #(
  .VEC_W(VEC_W), .GRAN_W(GRAN_W), .DP_W(DP_W)
) u_chk (.*);

// File: tb/fma_wb_merge_test.sv
module fma_wb_merge_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [255:0] dst_i = '0;
  logic [255:0] res_i = '0;
  logic         dbl_i = 1'b0;
  logic         scalar_i = 1'b0;
  logic         len256_i = 1'b0;
  logic         out_valid_o;
  logic [255:0] out_data_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic         m_valid = 1'b0;
  logic [255:0] m_data = '0;
  string        m_tag = "R1";

  always #4 clk_i = ~clk_i;

  fma_wb_merge uut (.*);

  function automatic logic [255:0] ref_merge(input logic [255:0] d, input logic [255:0] r,
                                             input logic dbl, input logic sc, input logic l256);
    logic [255:0] o;
    o = '0;
    if (!sc) begin
      o[127:0] = r[127:0];
      if (l256) o[255:128] = r[255:128];
    end else begin
      o[127:0] = d[127:0];
      if (dbl) o[63:0] = r[63:0];
      else     o[31:0] = r[31:0];
    end
    return o;
  endfunction

  function automatic string mode_tag(input logic dbl, input logic sc, input logic l256);
    if (sc) return dbl ? "R6" : "R5";
    return l256 ? "R3 R7" : "R4 R7";
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle: compare outputs with the model, then drive the next input
  task automatic step(input logic v, input logic [255:0] d, input logic [255:0] r,
                      input logic dbl, input logic sc, input logic l256);
    @(negedge clk_i);
    chk_bit("R2", out_valid_o, m_valid);
    chk_word(m_tag, out_data_o, m_data);
    in_valid_i = v; dst_i = d; res_i = r;
    dbl_i = dbl; scalar_i = sc; len256_i = l256;
    m_valid = v;
    if (v) begin
      m_data = ref_merge(d, r, dbl, sc, l256);
      m_tag  = mode_tag(dbl, sc, l256);
    end else begin
      m_tag = "R8";
    end
  endtask

  task automatic rand_word(output logic [255:0] w);
    for (int i = 0; i < 8; i++) w[i*32 +: 32] = $urandom;
  endtask

  initial begin
    logic [255:0] d, r;
    #1;
    chk_bit("R1", out_valid_o, 1'b0);
    chk_word("R1", out_data_o, '0);
    repeat (2) @(negedge clk_i);
    chk_bit("R1", out_valid_o, 1'b0);
    chk_word("R1", out_data_o, '0);
    rst_ni = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 6; p++) begin
        case (p)
          0: begin d = '0; r = '1; end
          1: begin d = '1; r = '0; end
          2: begin d = {64{4'hA}}; r = {64{4'h5}}; end
          default: begin rand_word(d); rand_word(r); end
        endcase
        step(1'b1, d, r, m[2], m[1], m[0]);
        if (p % 2 == 0) begin
          rand_word(d); rand_word(r);
          step(1'b0, d, r, ~m[2], ~m[1], ~m[0]);
        end
      end
    end

    // packed: same operands with both precisions, back to back
    for (int l = 0; l < 2; l++) begin
      rand_word(d); rand_word(r);
      step(1'b1, d, r, 1'b0, 1'b0, l[0]);
      step(1'b1, d, r, 1'b1, 1'b0, l[0]);
    end
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '1, '1, 1'b1, 1'b1, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule